// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the register slave of a color LCD controller. It occupies a 4 KB address window on a simple single-cycle read/write bus. It holds the four panel timing words, the two frame base addresses, the control word, an interrupt mask and a sticky interrupt status. From these it produces the panel geometry, the enable state and the pixel-format controls that the rest of the controller uses.

The palette is not stored here. Any access that falls in the palette window is passed on to an external palette RAM, and the read data that RAM returns is sent back to the bus. A run of read-only identification bytes sits at the top of the window.

A parameter selects one of two register-map variants. The variants differ in their identification bytes and in which of two adjacent offsets holds the control word and which holds the mask. Event inputs set status bits. Whenever the derived width, height or enable state changes, the block raises a one-cycle pulse, so that a downstream display path knows to re-size.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every stored register is zero, `ppl` is 16, `lpp` is 1, `lcd_on` is 0, `geom_chg` is 0 and `rdata` is 0.
- R2: The timing words at byte offsets 0x000, 0x004, 0x008 and 0x00C, the upper base at 0x010 and the lower base at 0x014 read back the full 32 bits last written. The current-address registers at 0x02C and 0x030 read as the upper and lower base.
- R3: With `VARIANT` = original, offset 0x018 is the control word (16 bits kept) and 0x01C is the mask (NIRQ bits kept). With `VARIANT` = newer, the two are swapped.
- R4: `ppl` = ((timing0 & 0xFC) + 4) * 4 and `lpp` = (timing1 & 0x3FF) + 1, both valid the cycle after the write.
- R5: `lcd_on` is 1 only when control bit 0 (enable) and bit 11 (power) are both 1. `bpp_code` is control bits [3:1], `bgr_sel` is bit 8, `be_bytes` is bit 9 and `be_pixels` is bit 10.
- R6: A 1 on any `irq_evt` bit sets the matching raw status bit, which stays set. Raw status reads at 0x020 and masked status (raw AND mask) at 0x024.
- R7: A write to 0x028 clears every raw status bit that is 1 in the write data. An event in the same cycle wins over the clear, and 0x028 reads as 0.
- R8: Word k (k = 0..7) at byte offset 0xFE0 + 4k returns one identification byte in bits [7:0], with zero above. The bytes are 10 11 04 00 0D F0 05 B1 for the original variant and 11 11 24 00 0D F0 05 B1 for the newer one.
- R9: Byte offsets 0x200 to 0x3FF assert `pal_sel` with `pal_idx` = addr[8:2], `pal_wr` = `bus_wr` and `pal_wdata` = `wdata` in the same cycle. A palette read returns `pal_rdata` on `rdata` the next cycle. Outside the window `pal_sel` is 0.
- R10: Undefined offsets read as 0. Writes to undefined offsets, to status, to the current-address registers and to the identification bytes change nothing.
- R11: `geom_chg` is high for exactly the one cycle after an edge at which `ppl`, `lpp` or `lcd_on` changed value, and is low otherwise.
- R12: `rdata` is loaded at the edge that samples a read and holds its value through idle and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_evt | input | NIRQ | Status set events |
| pal_sel | output | 1 | Palette window access |
| pal_wr | output | 1 | Palette write |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data, combinational |
| ppl | output | 12 | Pixels per line |
| lpp | output | 11 | Lines per panel |
| lcd_on | output | 1 | Controller enabled and powered |
| bpp_code | output | 3 | Bits-per-pixel code |
| bgr_sel | output | 1 | BGR color order |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order |
| geom_chg | output | 1 | One-cycle geometry/enable change pulse |

## Verification
A register write takes effect at the edge that samples it. The geometry, enable and format outputs therefore change one cycle after the write is presented, and `geom_chg` is high during that same following cycle only. Read data is registered, so it is due one cycle after the read strobe. The palette strobes are combinational and are due within the strobe cycle. The bench drives on falling edges and samples at the next falling edge, or a short delay after driving for the combinational palette outputs, so each value is observed exactly in its due cycle.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int PAL_IW = 7;

    // control word bit positions (decoded by the display path)
    localparam int CB_EN   = 0;
    localparam int CB_BPP  = 1;
    localparam int CB_BGR  = 8;
    localparam int CB_BEB  = 9;
    localparam int CB_BEP  = 10;
    localparam int CB_PWR  = 11;

    typedef enum logic [0:0] {
        VAR_ORIG = 1'b0,
        VAR_NEW  = 1'b1
    } lcdc_variant_e;

    typedef enum logic [3:0] {
        RG_NONE, RG_TIM, RG_UPB, RG_LPB, RG_MASK, RG_CTRL, RG_RAW,
        RG_MIS, RG_ICR, RG_UPCUR, RG_LPCUR, RG_PAL, RG_ID
    } lcdc_region_e;

    typedef struct packed {
        lcdc_region_e region;
        logic [2:0]   sub;
    } lcdc_dec_t;

    typedef struct packed {
        logic [11:0] ppl;
        logic [10:0] lpp;
        logic        on;
    } lcdc_geom_t;

    localparam lcdc_geom_t GEOM_RST = '{ppl: 12'd16, lpp: 11'd1, on: 1'b0};

    function automatic logic [7:0] id_byte(lcdc_variant_e v, logic [2:0] k);
        case (k)
            3'd0:    return (v == VAR_NEW) ? 8'h11 : 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return (v == VAR_NEW) ? 8'h24 : 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
    import lcdc_pkg::*;
#(
    parameter lcdc_variant_e VARIANT = VAR_ORIG
) (
    input  logic [ADDR_W-1:0] addr,
    output lcdc_dec_t         dec
);
    localparam lcdc_region_e R_AT6 = (VARIANT == VAR_NEW) ? RG_MASK : RG_CTRL;
    localparam lcdc_region_e R_AT7 = (VARIANT == VAR_NEW) ? RG_CTRL : RG_MASK;

    logic [ADDR_W-3:0] word;
    assign word = addr[ADDR_W-1:2];

    always_comb begin
        dec.region = RG_NONE;
        dec.sub    = addr[4:2];
        if (addr[11:9] == 3'b001) begin
            dec.region = RG_PAL;
        end else if (addr[11:5] == 7'h7F) begin
            dec.region = RG_ID;
        end else begin
            case (word)
                10'd0, 10'd1, 10'd2, 10'd3: dec.region = RG_TIM;
                10'd4:  dec.region = RG_UPB;
                10'd5:  dec.region = RG_LPB;
                10'd6:  dec.region = R_AT6;
                10'd7:  dec.region = R_AT7;
                10'd8:  dec.region = RG_RAW;
                10'd9:  dec.region = RG_MIS;
                10'd10: dec.region = RG_ICR;
                10'd11: dec.region = RG_UPCUR;
                10'd12: dec.region = RG_LPCUR;
                default: dec.region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lcdc_irq_stat.sv
module lcdc_irq_stat #(
    parameter int NIRQ = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] evt,
    input  logic            mask_we,
    input  logic            clr_we,
    input  logic [NIRQ-1:0] wbits,
    output logic [NIRQ-1:0] raw,
    output logic [NIRQ-1:0] mask,
    output logic [NIRQ-1:0] masked
);
    logic [NIRQ-1:0] clr_bits;
    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | evt;
            if (mask_we) mask <= wbits;
        end
    end

    assign masked = raw & mask;
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tim0,
    input  logic [DATA_W-1:0] tim1,
    input  logic [CTRL_W-1:0] ctrl,
    output lcdc_geom_t        geom,
    output logic              chg
);
    lcdc_geom_t prev_q;

    always_comb begin
        geom.ppl = ({4'd0, tim0[7:2], 2'b00} + 12'd4) << 2;
        geom.lpp = {1'b0, tim1[9:0]} + 11'd1;
        geom.on  = ctrl[CB_EN] & ctrl[CB_PWR];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= GEOM_RST;
        else     prev_q <= geom;
    end

    assign chg = (geom != prev_q);
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter lcdc_variant_e VARIANT = VAR_ORIG,
    parameter int NIRQ   = 5,
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NIRQ-1:0]   irq_evt,
    output logic              pal_sel,
    output logic              pal_wr,
    output logic [6:0]        pal_idx,
    output logic [31:0]       pal_wdata,
    input  logic [31:0]       pal_rdata,
    output logic [11:0]       ppl,
    output logic [10:0]       lpp,
    output logic              lcd_on,
    output logic [2:0]        bpp_code,
    output logic              bgr_sel,
    output logic              be_bytes,
    output logic              be_pixels,
    output logic              geom_chg
);
    localparam int NTIM   = 4;
    localparam int TIM_IW = $clog2(NTIM);

    lcdc_dec_t   dec;
    logic        wr_hit, rd_hit;
    logic [DATA_W-1:0] tim_q [NTIM];
    logic [DATA_W-1:0] upb_q, lpb_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [NIRQ-1:0]   raw, mask, masked;
    lcdc_geom_t        geom;
    logic [DATA_W-1:0] rd_val;

    assign wr_hit = bus_sel & bus_wr;
    assign rd_hit = bus_sel & ~bus_wr;

    lcdc_addr_dec #(.VARIANT(VARIANT)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar i = 0; i < NTIM; i++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst)
                tim_q[i] <= '0;
            else if (wr_hit && dec.region == RG_TIM && dec.sub[TIM_IW-1:0] == TIM_IW'(i))
                tim_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upb_q  <= '0;
            lpb_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_hit) begin
            case (dec.region)
                RG_UPB:  upb_q  <= wdata;
                RG_LPB:  lpb_q  <= wdata;
                RG_CTRL: ctrl_q <= wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    lcdc_irq_stat #(.NIRQ(NIRQ)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .evt     (irq_evt),
        .mask_we (wr_hit && dec.region == RG_MASK),
        .clr_we  (wr_hit && dec.region == RG_ICR),
        .wbits   (wdata[NIRQ-1:0]),
        .raw     (raw),
        .mask    (mask),
        .masked  (masked)
    );

    lcdc_geom #(.CTRL_W(CTRL_W)) u_geom (
        .clk  (clk),
        .rst  (rst),
        .tim0 (tim_q[0]),
        .tim1 (tim_q[1]),
        .ctrl (ctrl_q),
        .geom (geom),
        .chg  (geom_chg)
    );

    always_comb begin
        rd_val = '0;
        case (dec.region)
            RG_TIM:            rd_val = tim_q[dec.sub[TIM_IW-1:0]];
            RG_UPB, RG_UPCUR:  rd_val = upb_q;
            RG_LPB, RG_LPCUR:  rd_val = lpb_q;
            RG_CTRL:           rd_val[CTRL_W-1:0] = ctrl_q;
            RG_MASK:           rd_val[NIRQ-1:0]   = mask;
            RG_RAW:            rd_val[NIRQ-1:0]   = raw;
            RG_MIS:            rd_val[NIRQ-1:0]   = masked;
            RG_ID:             rd_val[7:0]        = id_byte(VARIANT, dec.sub);
            RG_PAL:            rd_val = pal_rdata;
            default:           rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (rd_hit) rdata <= rd_val;
    end

    assign pal_sel   = bus_sel && dec.region == RG_PAL;
    assign pal_wr    = pal_sel & bus_wr;
    assign pal_idx   = addr[PAL_IW+1:2];
    assign pal_wdata = wdata;

    assign ppl       = geom.ppl;
    assign lpp       = geom.lpp;
    assign lcd_on    = geom.on;
    assign bpp_code  = ctrl_q[CB_BPP +: 3];
    assign bgr_sel   = ctrl_q[CB_BGR];
    assign be_bytes  = ctrl_q[CB_BEB];
    assign be_pixels = ctrl_q[CB_BEP];
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [11:0] addr,
    input logic [31:0] rdata,
    input logic        pal_sel,
    input logic [11:0] ppl,
    input logic [10:0] lpp,
    input logic        lcd_on,
    input logic        geom_chg
);
    // R11: a pulse always has a cause in the previous cycle's geometry
    a_r11_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
        geom_chg |-> (ppl != $past(ppl) || lpp != $past(lpp) || lcd_on != $past(lcd_on)));

    // R11: every geometry change is announced
    a_r11_change_pulses: assert property (@(posedge clk) disable iff (rst)
        (ppl != $past(ppl) || lpp != $past(lpp) || lcd_on != $past(lcd_on)) |-> geom_chg);

    // R9: palette strobe only inside its window
    a_r9_pal_window: assert property (@(posedge clk) disable iff (rst)
        pal_sel |-> (bus_sel && addr[11:9] == 3'b001));

    // R12: read data holds when no read is sampled
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> $stable(rdata));

    // R8: identification words carry one byte only
    a_r8_id_byte_only: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && addr[11:5] == 7'h7F) |=> rdata[31:8] == 24'd0);

    // R10: undefined offsets between 0x034 and 0x1FC read as zero
    a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && addr[11:9] == 3'b000 && addr[8:2] > 7'd12) |=> rdata == 32'd0);

    // R4: height never leaves its derived range
    a_r4_lpp_range: assert property (@(posedge clk) disable iff (rst)
        lpp >= 11'd1 && lpp <= 11'd1024);
endmodule

bind lcdc_regs lcdc_regs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .addr     (addr),
    .rdata    (rdata),
    .pal_sel  (pal_sel),
    .ppl      (ppl),
    .lpp      (lpp),
    .lcd_on   (lcd_on),
    .geom_chg (geom_chg)
);

// File: tb/lcdc_regs_tb_top.sv
module lcdc_regs_tb_top;
    import lcdc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [NIRQ-1:0] irq_evt = '0;
    logic [31:0] pal_rdata = '0;

    logic [31:0] rdata_a, rdata_b;
    logic pal_sel_a, pal_wr_a, pal_sel_b, pal_wr_b;
    logic [6:0] pal_idx_a, pal_idx_b;
    logic [31:0] pal_wdata_a, pal_wdata_b;
    logic [11:0] ppl_a, ppl_b;
    logic [10:0] lpp_a, lpp_b;
    logic on_a, on_b, bgr_a, bgr_b, beb_a, beb_b, bep_a, bep_b, chg_a, chg_b;
    logic [2:0] bpp_a, bpp_b;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdc_regs #(.VARIANT(VAR_ORIG), .NIRQ(NIRQ)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .addr(addr),
        .wdata(wdata), .rdata(rdata_a), .irq_evt(irq_evt),
        .pal_sel(pal_sel_a), .pal_wr(pal_wr_a), .pal_idx(pal_idx_a),
        .pal_wdata(pal_wdata_a), .pal_rdata(pal_rdata),
        .ppl(ppl_a), .lpp(lpp_a), .lcd_on(on_a), .bpp_code(bpp_a),
        .bgr_sel(bgr_a), .be_bytes(beb_a), .be_pixels(bep_a), .geom_chg(chg_a)
    );

    lcdc_regs #(.VARIANT(VAR_NEW), .NIRQ(NIRQ)) dut_n (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .addr(addr),
        .wdata(wdata), .rdata(rdata_b), .irq_evt(irq_evt),
        .pal_sel(pal_sel_b), .pal_wr(pal_wr_b), .pal_idx(pal_idx_b),
        .pal_wdata(pal_wdata_b), .pal_rdata(pal_rdata),
        .ppl(ppl_b), .lpp(lpp_b), .lcd_on(on_b), .bpp_code(bpp_b),
        .bgr_sel(bgr_b), .be_bytes(beb_b), .be_pixels(bep_b), .geom_chg(chg_b)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 31;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 12'h000, 32'h0000_00FF, 32'h0, 32'h0, 4'd2},                 // R2
        '{1'b0, 12'h000, 32'h0, 32'h0000_00FF, 32'h0000_00FF, 4'd2},         // R2
        '{1'b1, 12'h004, 32'h0000_0123, 32'h0, 32'h0, 4'd2},                 // R2
        '{1'b0, 12'h004, 32'h0, 32'h0000_0123, 32'h0000_0123, 4'd2},         // R2
        '{1'b1, 12'h008, 32'hA5A5_A5A5, 32'h0, 32'h0, 4'd2},                 // R2
        '{1'b0, 12'h008, 32'h0, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 4'd2},         // R2
        '{1'b1, 12'h00C, 32'h0000_BEEF, 32'h0, 32'h0, 4'd2},                 // R2
        '{1'b0, 12'h00C, 32'h0, 32'h0000_BEEF, 32'h0000_BEEF, 4'd2},         // R2
        '{1'b1, 12'h010, 32'h8000_1000, 32'h0, 32'h0, 4'd2},                 // R2
        '{1'b0, 12'h010, 32'h0, 32'h8000_1000, 32'h8000_1000, 4'd2},         // R2
        '{1'b0, 12'h02C, 32'h0, 32'h8000_1000, 32'h8000_1000, 4'd2},         // R2
        '{1'b1, 12'h014, 32'h1234_5678, 32'h0, 32'h0, 4'd2},                 // R2
        '{1'b0, 12'h030, 32'h0, 32'h1234_5678, 32'h1234_5678, 4'd2},         // R2
        '{1'b1, 12'h018, 32'h0000_0FFF, 32'h0, 32'h0, 4'd3},                 // R3
        '{1'b0, 12'h018, 32'h0, 32'h0000_0FFF, 32'h0000_001F, 4'd3},         // R3
        '{1'b0, 12'h01C, 32'h0, 32'h0, 32'h0, 4'd3},                         // R3
        '{1'b1, 12'h01C, 32'h0000_0003, 32'h0, 32'h0, 4'd3},                 // R3
        '{1'b0, 12'h01C, 32'h0, 32'h0000_0003, 32'h0000_0003, 4'd3},         // R3
        '{1'b0, 12'h018, 32'h0, 32'h0000_0FFF, 32'h0000_001F, 4'd3},         // R3
        '{1'b0, 12'hFE0, 32'h0, 32'h0000_0010, 32'h0000_0011, 4'd8},         // R8
        '{1'b0, 12'hFE8, 32'h0, 32'h0000_0004, 32'h0000_0024, 4'd8},         // R8
        '{1'b0, 12'hFFC, 32'h0, 32'h0000_00B1, 32'h0000_00B1, 4'd8},         // R8
        '{1'b1, 12'hFE0, 32'hFFFF_FFFF, 32'h0, 32'h0, 4'd10},                // R10
        '{1'b0, 12'hFE0, 32'h0, 32'h0000_0010, 32'h0000_0011, 4'd10},        // R10
        '{1'b1, 12'h040, 32'h0000_DEAD, 32'h0, 32'h0, 4'd10},                // R10
        '{1'b0, 12'h040, 32'h0, 32'h0, 32'h0, 4'd10},                        // R10
        '{1'b1, 12'h020, 32'h0000_00FF, 32'h0, 32'h0, 4'd10},                // R10
        '{1'b0, 12'h020, 32'h0, 32'h0, 32'h0, 4'd10},                        // R10
        '{1'b0, 12'h028, 32'h0, 32'h0, 32'h0, 4'd7},                         // R7
        '{1'b1, 12'h02C, 32'h0000_0999, 32'h0, 32'h0, 4'd10},                // R10
        '{1'b0, 12'h010, 32'h0, 32'h8000_1000, 32'h8000_1000, 4'd10}         // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // write presented for one cycle; returns at the falling edge after it is taken
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] ra, output logic [31:0] rb);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        ra = rdata_a;
        rb = rdata_b;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;

        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1 ppl", 32'(ppl_a), 32'd16);
        check("R1 lpp", 32'(lpp_a), 32'd1);
        check("R1 lcd_on", 32'(on_a), 32'd0);
        check("R1 geom_chg", 32'(chg_a), 32'd0);
        check("R1 rdata", rdata_a, 32'd0);
        bus_read(12'h018, ra, rb);
        check("R1 ctrl", ra, 32'd0);
        bus_read(12'h000, ra, rb);
        check("R1 timing0", ra, 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) begin
                bus_write(VEC[i].a, VEC[i].d);
            end else begin
                bus_read(VEC[i].a, ra, rb);
                check($sformatf("R%0d orig @%h", VEC[i].req, VEC[i].a), ra, VEC[i].ea);
                check($sformatf("R%0d new @%h", VEC[i].req, VEC[i].a), rb, VEC[i].eb);
            end
        end
        // after the table: orig ctrl 0xFFF, new ctrl 0x003
        check("R4 ppl max", 32'(ppl_a), 32'd1024);
        check("R4 lpp", 32'(lpp_a), 32'd292);
        check("R5 orig on", 32'(on_a), 32'd1);
        check("R5 orig bpp", 32'(bpp_a), 32'd7);
        check("R5 new on", 32'(on_b), 32'd0);
        check("R5 new bpp", 32'(bpp_b), 32'd1);

        // R11 / R5: enable and power
        do_reset();
        bus_write(12'h018, 32'h0000_0801);
        check("R5 on", 32'(on_a), 32'd1);
        check("R11 pulse", 32'(chg_a), 32'd1);
        @(negedge clk);
        check("R11 pulse ends", 32'(chg_a), 32'd0);
        bus_write(12'h018, 32'h0000_0801);
        check("R11 same value no pulse", 32'(chg_a), 32'd0);
        bus_write(12'h018, 32'h0000_0001);
        check("R5 enable without power", 32'(on_a), 32'd0);
        check("R11 pulse on disable", 32'(chg_a), 32'd1);
        bus_write(12'h018, 32'h0000_050A);
        check("R5 bpp", 32'(bpp_a), 32'd5);
        check("R5 bgr", 32'(bgr_a), 32'd1);
        check("R5 be_bytes", 32'(beb_a), 32'd0);
        check("R5 be_pixels", 32'(bep_a), 32'd1);
        check("R11 format only no pulse", 32'(chg_a), 32'd0);

        // R4: geometry arithmetic
        bus_write(12'h000, 32'h0000_0003);
        check("R4 low bits ignored", 32'(ppl_a), 32'd16);
        check("R11 unchanged ppl no pulse", 32'(chg_a), 32'd0);
        bus_write(12'h000, 32'h0000_0007);
        check("R4 ppl 32", 32'(ppl_a), 32'd32);
        check("R11 ppl change pulse", 32'(chg_a), 32'd1);
        bus_write(12'h004, 32'hFFFF_FC00);
        check("R4 lpp high bits ignored", 32'(lpp_a), 32'd1);
        bus_write(12'h004, 32'h0000_03FF);
        check("R4 lpp max", 32'(lpp_a), 32'd1024);
        check("R11 lpp change pulse", 32'(chg_a), 32'd1);

        // R6 / R7: status
        do_reset();
        bus_write(12'h01C, 32'h0000_0005);
        @(negedge clk);
        irq_evt = 5'h13;
        @(negedge clk);
        irq_evt = '0;
        bus_read(12'h020, ra, rb);
        check("R6 raw", ra, 32'h13);
        bus_read(12'h024, ra, rb);
        check("R6 masked", ra, 32'h01);
        bus_write(12'h028, 32'h0000_0003);
        bus_read(12'h020, ra, rb);
        check("R7 partial clear", ra, 32'h10);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; addr = 12'h028; wdata = 32'h10; irq_evt = 5'h10;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; irq_evt = '0;
        bus_read(12'h020, ra, rb);
        check("R7 event beats clear", ra, 32'h10);
        bus_write(12'h028, 32'h0000_001F);
        bus_read(12'h020, ra, rb);
        check("R7 full clear", ra, 32'h0);

        // R9 / R12: palette forwarding
        pal_rdata = 32'hCAFE_F00D;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; addr = 12'h3FC;
        #1;
        check("R9 pal_sel read", 32'(pal_sel_a), 32'd1);
        check("R9 pal_idx top", 32'(pal_idx_a), 32'd127);
        check("R9 pal_wr read", 32'(pal_wr_a), 32'd0);
        @(negedge clk);
        bus_sel = 1'b0;
        check("R9 palette read data", rdata_a, 32'hCAFE_F00D);
        pal_rdata = 32'h0;
        repeat (2) @(negedge clk);
        check("R12 hold idle", rdata_a, 32'hCAFE_F00D);
        bus_sel = 1'b1; bus_wr = 1'b1; addr = 12'h204; wdata = 32'h55;
        #1;
        check("R9 pal_sel write", 32'(pal_sel_a), 32'd1);
        check("R9 pal_wr write", 32'(pal_wr_a), 32'd1);
        check("R9 pal_idx", 32'(pal_idx_a), 32'd1);
        check("R9 pal_wdata", pal_wdata_a, 32'h55);
        @(negedge clk);
        check("R12 hold through write", rdata_a, 32'hCAFE_F00D);
        addr = 12'h400;
        #1;
        check("R9 outside window", 32'(pal_sel_a), 32'd0);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(12'h000, ra, rb);
        check("R10 palette write leaves timing", ra, 32'h0000_0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule